// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Interlock

This block resolves read-after-write data hazards for a five-stage, in-order integer pipeline (IF, ID, EX, MEM, WB). Operands are read in ID and results are written in WB. Because every instruction reads and writes in those same fixed stages, only read-after-write ordering needs handling. The block contains the integer register file, which writes first and reads second within a cycle. An instruction in ID therefore sees a value that WB is retiring in that same cycle.

For the instruction in EX, the block picks a source for each ALU operand. The source is the register file value latched in ID, the result held by the instruction now in MEM, or the result held by the instruction now in WB. The younger producer wins. A load result only exists once MEM completes, so a consumer directly behind a load cannot be fed by forwarding. For that case the block raises a stall. The stall holds PC and IF/ID and sends a bubble into EX. One cycle later the load sits in WB and forwarding, or the register file bypass, supplies its value.

Top module: `hazard_ctl`

## Requirements
- R1: On a rising clock edge with `wb_we_i` high and `wb_rd_i` non-zero, `wb_data_i` is stored in register `wb_rd_i`. `id_rdata1_o` and `id_rdata2_o` show, without a clock, the stored value of the register named by `id_rs1_i` and `id_rs2_i`.
- R2: When WB writes a non-zero register in the same cycle that ID reads it, the read port shows `wb_data_i`, not the old contents.
- R3: Register 0 always reads as zero, and writes to it have no effect.
- R4: An operand select is 2'b10 (take the MEM-stage result) when the MEM-stage instruction writes a non-zero register equal to that EX source.
- R5: An operand select is 2'b01 (take the WB-stage result) when the WB-stage instruction writes a non-zero register equal to that EX source and R4 does not apply.
- R6: Otherwise an operand select is 2'b00 (register file value). A destination of register 0 is never forwarded, and 2'b11 never appears.
- R7: When both the MEM and WB instructions match a source, the select is 2'b10.
- R8: `stall_o` is high exactly when the EX instruction is a load (`ex_load_i` and `ex_we_i`) with a non-zero destination that equals `id_rs1_i` or `id_rs2_i`.
- R9: A non-load producer in EX never raises `stall_o`, whatever its destination.
- R10: After an asynchronous reset, every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs1_i | input | AW | First source register of the ID instruction |
| id_rs2_i | input | AW | Second source register of the ID instruction |
| ex_rs1_i | input | AW | First source register of the EX instruction |
| ex_rs2_i | input | AW | Second source register of the EX instruction |
| ex_rd_i | input | AW | Destination register of the EX instruction |
| ex_we_i | input | 1 | EX instruction writes a register |
| ex_load_i | input | 1 | EX instruction is a load |
| mem_rd_i | input | AW | Destination register of the MEM instruction |
| mem_we_i | input | 1 | MEM instruction writes a register |
| wb_rd_i | input | AW | Destination register of the WB instruction |
| wb_we_i | input | 1 | WB instruction writes a register |
| wb_data_i | input | XLEN | Result retired by WB |
| id_rdata1_o | output | XLEN | Register file value for `id_rs1_i` |
| id_rdata2_o | output | XLEN | Register file value for `id_rs2_i` |
| fwd_a_o | output | 2 | Source select for ALU operand A |
| fwd_b_o | output | 2 | Source select for ALU operand B |
| stall_o | output | 1 | Hold PC and IF/ID, insert bubble into EX |

## Verification
The assertions take the stage inputs to be stable between clock edges and driven from reset onward. They place no constraint on whether the inputs form a legal instruction stream. As a result, a load can appear in EX while its consumer stays in ID for any number of cycles. The stimulus draws register numbers from a narrow range so that matches in all three stages, double matches and register-0 destinations occur often. It changes inputs only just after a rising edge, so every combinational output is settled when it is sampled at the falling edge.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/hazard_rf.sv
module hazard_rf #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic [XLEN-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]    raddr_i,
  output logic [NRD-1:0][XLEN-1:0]  rdata_o
);
  logic [XLEN-1:0] mem_q [NREGS];
  logic            wr_ok;

  assign wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
    end else if (wr_ok) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // write-first: a same-cycle write is visible to the read ports
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      if (raddr_i[r] == '0)                  rdata_o[r] = '0;
      else if (wr_ok && waddr_i == raddr_i[r]) rdata_o[r] = wdata_i;
      else                                   rdata_o[r] = mem_q[raddr_i[r]];
    end
  end
endmodule

// File: rtl/hazard_fwd_sel.sv
module hazard_fwd_sel
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_rd_i,
  output logic [1:0]    sel_o
);
  logic hit_mem, hit_wb;
  opnd_sel_e sel;

  assign hit_mem = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_i);
  assign hit_wb  = wb_we_i  && (wb_rd_i  != '0) && (wb_rd_i  == src_i);

  // younger producer first
  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  assign sel_o = sel;
endmodule

// File: rtl/hazard_lu_det.sv
module hazard_lu_det #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                   ex_load_i,
  input  logic                   ex_we_i,
  input  logic [AW-1:0]          ex_rd_i,
  input  logic [NSRC-1:0][AW-1:0] id_src_i,
  output logic                   stall_o
);
  logic [NSRC-1:0] dep;
  logic            ld_live;

  assign ld_live = ex_load_i && ex_we_i && (ex_rd_i != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign dep[s] = (id_src_i[s] == ex_rd_i);
  end

  assign stall_o = ld_live && (|dep);
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   id_rs1_i,
  input  logic [AW-1:0]   id_rs2_i,
  input  logic [AW-1:0]   ex_rs1_i,
  input  logic [AW-1:0]   ex_rs2_i,
  input  logic [AW-1:0]   ex_rd_i,
  input  logic            ex_we_i,
  input  logic            ex_load_i,
  input  logic [AW-1:0]   mem_rd_i,
  input  logic            mem_we_i,
  input  logic [AW-1:0]   wb_rd_i,
  input  logic            wb_we_i,
  input  logic [XLEN-1:0] wb_data_i,
  output logic [XLEN-1:0] id_rdata1_o,
  output logic [XLEN-1:0] id_rdata2_o,
  output logic [1:0]      fwd_a_o,
  output logic [1:0]      fwd_b_o,
  output logic            stall_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0]   id_src, ex_src;
  logic [NSRC-1:0][XLEN-1:0] rdata;
  logic [NSRC-1:0][1:0]      sel;

  assign id_src = {id_rs2_i, id_rs1_i};
  assign ex_src = {ex_rs2_i, ex_rs1_i};

  hazard_rf #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NSRC)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_we_i),
    .waddr_i (wb_rd_i),
    .wdata_i (wb_data_i),
    .raddr_i (id_src),
    .rdata_o (rdata)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_fwd
    hazard_fwd_sel #(.AW(AW)) u_sel (
      .src_i    (ex_src[s]),
      .mem_we_i (mem_we_i),
      .mem_rd_i (mem_rd_i),
      .wb_we_i  (wb_we_i),
      .wb_rd_i  (wb_rd_i),
      .sel_o    (sel[s])
    );
  end

  hazard_lu_det #(.AW(AW), .NSRC(NSRC)) u_lu (
    .ex_load_i (ex_load_i),
    .ex_we_i   (ex_we_i),
    .ex_rd_i   (ex_rd_i),
    .id_src_i  (id_src),
    .stall_o   (stall_o)
  );

  assign id_rdata1_o = rdata[0];
  assign id_rdata2_o = rdata[1];
  assign fwd_a_o     = sel[0];
  assign fwd_b_o     = sel[1];
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   id_rs1_i,
  input logic [AW-1:0]   id_rs2_i,
  input logic [AW-1:0]   ex_rs1_i,
  input logic [AW-1:0]   ex_rs2_i,
  input logic [AW-1:0]   ex_rd_i,
  input logic            ex_we_i,
  input logic            ex_load_i,
  input logic [AW-1:0]   mem_rd_i,
  input logic            mem_we_i,
  input logic [AW-1:0]   wb_rd_i,
  input logic            wb_we_i,
  input logic [XLEN-1:0] wb_data_i,
  input logic [XLEN-1:0] id_rdata1_o,
  input logic [XLEN-1:0] id_rdata2_o,
  input logic [1:0]      fwd_a_o,
  input logic [1:0]      fwd_b_o,
  input logic            stall_o
);
  // R1
  rf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wb_we_i && $stable(id_rs1_i) && id_rs1_i != '0) |=> (!wb_we_i && $stable(id_rs1_i)) -> $stable(id_rdata1_o));

  // R2
  wr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_i && wb_rd_i != '0 && wb_rd_i == id_rs2_i) |-> id_rdata2_o == wb_data_i);

  // R3
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs1_i == '0) |-> id_rdata1_o == '0);

  // R4
  mem_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == 2'b10) |-> (mem_we_i && mem_rd_i != '0 && mem_rd_i == ex_rs1_i));

  // R5
  wb_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_b_o == 2'b01) |-> (wb_we_i && wb_rd_i != '0 && wb_rd_i == ex_rs2_i &&
                            !(mem_we_i && mem_rd_i == ex_rs2_i)));

  // R6
  sel_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_a_o != 2'b11 && fwd_b_o != 2'b11);

  // R7
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && mem_rd_i != '0 && mem_rd_i == ex_rs2_i) |-> fwd_b_o == 2'b10);

  // R8
  stall_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_rd_i != '0 && (ex_rd_i == id_rs1_i || ex_rd_i == id_rs2_i)));

  // R9
  stall_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_load_i |-> !stall_o);
endmodule

bind hazard_ctl hazard_ctl_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i),
  .ex_rs1_i(ex_rs1_i), .ex_rs2_i(ex_rs2_i),
  .ex_rd_i(ex_rd_i), .ex_we_i(ex_we_i), .ex_load_i(ex_load_i),
  .mem_rd_i(mem_rd_i), .mem_we_i(mem_we_i),
  .wb_rd_i(wb_rd_i), .wb_we_i(wb_we_i), .wb_data_i(wb_data_i),
  .id_rdata1_o(id_rdata1_o), .id_rdata2_o(id_rdata2_o),
  .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o), .stall_o(stall_o)
);

// File: tb/sim_hazard_ctl.sv
`timescale 1ns/1ps
module sim_hazard_ctl;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int AW    = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
  logic [AW-1:0] mem_rd = '0, wb_rd = '0;
  logic ex_we = 1'b0, ex_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
  logic [XLEN-1:0] wb_data = '0;
  logic [XLEN-1:0] rd1, rd2;
  logic [1:0] fa, fb;
  logic stall;

  int checks = 0;
  int failures = 0;
  logic [XLEN-1:0] mregs [NREGS];

  always #10 clk = ~clk;

  hazard_ctl #(.XLEN(XLEN), .NREGS(NREGS)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we), .wb_data_i(wb_data),
    .id_rdata1_o(rd1), .id_rdata2_o(rd2),
    .fwd_a_o(fa), .fwd_b_o(fb), .stall_o(stall)
  );

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_rd(logic [AW-1:0] rs);
    if (rs == 0) return '0;
    if (wb_we && wb_rd == rs) return wb_data;
    return mregs[rs];
  endfunction

  function automatic string rd_tag(logic [AW-1:0] rs);
    if (rs == 0) return "R3";
    if (wb_we && wb_rd == rs) return "R2";
    return "R1";
  endfunction

  function automatic logic [1:0] exp_sel(logic [AW-1:0] rs);
    if (mem_we && mem_rd != 0 && mem_rd == rs) return 2'b10;
    if (wb_we && wb_rd != 0 && wb_rd == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(logic [AW-1:0] rs);
    bit m, w;
    m = mem_we && mem_rd != 0 && mem_rd == rs;
    w = wb_we && wb_rd != 0 && wb_rd == rs;
    if (m && w) return "R7";
    if (m) return "R4";
    if (w) return "R5";
    return "R6";
  endfunction

  task automatic step();
    logic exp_st;
    @(negedge clk);
    chk(rd_tag(id_rs1), rd1, exp_rd(id_rs1));
    chk(rd_tag(id_rs2), rd2, exp_rd(id_rs2));
    chk(sel_tag(ex_rs1), {30'd0, fa}, {30'd0, exp_sel(ex_rs1)});
    chk(sel_tag(ex_rs2), {30'd0, fb}, {30'd0, exp_sel(ex_rs2)});
    exp_st = ex_load && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    chk(ex_load ? "R8" : "R9", {31'd0, stall}, {31'd0, exp_st});
    @(posedge clk);
    if (wb_we && wb_rd != 0) mregs[wb_rd] = wb_data;
    #1;
  endtask

  task automatic rnd_inputs(int span);
    id_rs1  = AW'($urandom_range(span));
    id_rs2  = AW'($urandom_range(span));
    ex_rs1  = AW'($urandom_range(span));
    ex_rs2  = AW'($urandom_range(span));
    ex_rd   = AW'($urandom_range(span));
    mem_rd  = AW'($urandom_range(span));
    wb_rd   = AW'($urandom_range(span));
    ex_we   = 1'($urandom);
    ex_load = 1'($urandom);
    mem_we  = 1'($urandom);
    wb_we   = 1'($urandom);
    wb_data = $urandom;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) mregs[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: all registers zero after reset
    for (int i = 1; i < NREGS; i++) begin
      id_rs1 = AW'(i);
      id_rs2 = AW'(NREGS - i);
      @(negedge clk);
      chk("R10", rd1, '0);
      chk("R10", rd2, '0);
      @(posedge clk); #1;
    end

    // R3: write to register 0 has no effect
    wb_we = 1'b1; wb_rd = '0; wb_data = 32'hDEAD_BEEF; id_rs1 = '0;
    step();
    wb_we = 1'b0;
    step();

    // R8: load-use on rs2, then register 0 destination
    ex_load = 1'b1; ex_we = 1'b1; ex_rd = 5'd5; id_rs1 = 5'd3; id_rs2 = 5'd5;
    step();
    ex_rd = '0; id_rs2 = '0;
    step();
    // R9: ALU producer with matching destination
    ex_load = 1'b0; ex_rd = 5'd3;
    step();

    // R7 / R4 / R5: both stages match
    ex_we = 1'b0; mem_we = 1'b1; mem_rd = 5'd7; wb_we = 1'b1; wb_rd = 5'd7;
    wb_data = 32'h1234_5678; ex_rs1 = 5'd7; ex_rs2 = 5'd7; id_rs1 = 5'd7;
    step();
    mem_rd = 5'd9;
    step();
    wb_we = 1'b0; mem_rd = '0;
    step();

    for (int n = 0; n < 3000; n++) begin
      rnd_inputs((n % 3 == 0) ? NREGS - 1 : 3);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule